// File: doc/BRIEF.md
# Dual-Counter Photon Pixel Logic

This block is the digital half of a photon-counting pixel. Two binary counters take charge-event pulses from the analog front end. The pair can be set to 1, 4 or 12 bits per counter, or joined into a single 24-bit counter. The same register bits form a serial shift chain, so one shift path handles both readout and clearing. Each bit shifted in from `serial_i` replaces a bit shifted out on `serial_o`.

There are three acquisition schemes. In the sequential scheme, both counters share one exposure and are then read back to back, with counting stopped during readout. In the continuous scheme, the counters alternate roles from frame to frame: one counts from the first event input while the other is shifted out, so no dead time occurs. In the semi-sequential scheme, each counter has its own shutter and shift enable. A counter stops at the all-ones value of its depth instead of wrapping. An asynchronous fast clear zeroes every counter bit at once.

Top module: `pxc_pixel`

## Requirements
- R1: While `rst_ni` is low, or once `fast_clr_i` has been high, every counter bit reads zero. `serial_o` is 0 whenever no counter is selected for shifting.
- R2: Sequential scheme (`mode_i`=0, and also the unused code 3). While `shutter_i[0]`=1 and `shift_en_i[0]`=0, counter 0 counts `evt_i[0]` and counter 1 counts `evt_i[1]`. `shutter_i[1]` has no effect. Each cycle with `shift_en_i[0]`=1 shifts the chain made of counter 0 followed by counter 1.
- R3: A counter that holds the all-ones value of its depth keeps that value when further events arrive. This also holds for the joined 24-bit counter.
- R4: Continuous scheme (`mode_i`=1). Counter 0 is active after reset and after any configuration change. The active counter counts `evt_i[0]` whenever `shutter_i[0]`=1, including while shifting is in progress. `evt_i[1]` is ignored. `shift_en_i[0]` shifts only the idle counter. The two roles swap on each falling edge of `shutter_i[0]`.
- R5: Semi-sequential scheme (`mode_i`=2). Counter k counts `evt_i[k]` while `shutter_i[k]`=1 and `shift_en_i[k]`=0. `shift_en_i[k]` shifts counter k only. If both enables are high, counter 0 is followed by counter 1 in one chain.
- R6: Depth code 3 joins the counters as {counter 1, counter 0}. This 24-bit counter counts `evt_i[0]` while `shutter_i[0]`=1 and `shift_en_i[0]`=0, in any scheme. `shift_en_i[0]` shifts all 24 bits.
- R7: Shifting emits least significant bit first, and a counter of depth D emits D bits. Bits taken from `serial_i` fill from the top of the chain. After a full-length shift, the chain therefore holds the shifted-in sequence in the same order. Shifting in zeros clears the counters.
- R8: `mode_i` and `depth_i` are captured only in a cycle where `shutter_i` and `shift_en_i` are all zero. Changes at any other time have no effect.
- R9: An event counts once per rising edge. An input held high counts one event.
- R10: Depth codes are 0 = 1 bit, 1 = 4 bits, 2 = 12 bits and 3 = joined 24 bits. When a counter is separate, its bits above the configured depth stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for counting and shifting |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_clr_i | input | 1 | Asynchronous clear of all counter bits, active high |
| mode_i | input | 2 | Scheme: 0 sequential, 1 continuous, 2 semi-sequential |
| depth_i | input | 2 | Depth: 0 1-bit, 1 4-bit, 2 12-bit, 3 joined 24-bit |
| shutter_i | input | 2 | Exposure gates; bit 1 is used only in semi-sequential |
| evt_i | input | 2 | Event pulses from the two thresholds |
| shift_en_i | input | 2 | Shift enables; bit 1 is used only in semi-sequential |
| serial_i | input | 1 | Serial data entering the top of the chain |
| serial_o | output | 1 | Serial data leaving, least significant bit first |

## Verification
Some properties are checked on every cycle. A counter at its depth limit stays at that limit, and a separate counter that is not shifting grows by at most one per cycle. Bits above the selected depth stay zero, and the configuration cannot change while a shutter or shift enable is active. In the continuous scheme, the idle counter is never disturbed by the second event input. Other behaviours can only be seen through the bench's scenarios. These are the bit order on the serial chain, the role swap between frames, counting that overlaps a readout, loading the chain from `serial_i`, and the saturation value reached at each depth.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_CONT = 2'd1,
    MODE_SEMI = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    DEPTH_ONE  = 2'd0,
    DEPTH_MID  = 2'd1,
    DEPTH_FULL = 2'd2,
    DEPTH_JOIN = 2'd3
  } depth_e;

  typedef struct packed {
    mode_e  mode;
    depth_e depth;
  } cfg_t;
endpackage

// File: rtl/pxc_evt_edge.sv
module pxc_evt_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] smp_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      dly_q <= '0;
    end else begin
      smp_q <= evt_i;
      dly_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~dly_q;
endmodule

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
  import pxc_pkg::*;
#(
  parameter int CW    = 12,
  parameter int MID_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    depth_i,
  input  logic [1:0]    shutter_i,
  input  logic [1:0]    shift_en_i,
  input  logic [1:0]    rise_i,
  output cfg_t          cfg_o,
  output logic          cfg_upd_o,
  output logic          act_o,
  output logic          join_nxt_o,
  output logic [CW-1:0] mask_nxt_o,
  output logic [1:0]    inc_o,
  output logic [1:0]    shf_o
);
  localparam logic [CW-1:0] MASK_ONE = CW'(1);
  localparam logic [CW-1:0] MASK_MID = CW'((1 << MID_W) - 1);
  localparam logic [CW-1:0] MASK_ALL = '1;

  cfg_t       cfg_q, cfg_in, cfg_d;
  logic [1:0] shut_q;
  logic       act_q, joined, cont, idle_ok;
  logic [1:0] cnt_en;
  logic       ev1;

  assign cfg_in    = cfg_t'{mode: mode_e'(mode_i), depth: depth_e'(depth_i)};
  assign idle_ok   = (shutter_i == 2'b00) && (shift_en_i == 2'b00);
  assign cfg_upd_o = idle_ok && (cfg_in != cfg_q);
  assign cfg_d     = cfg_upd_o ? cfg_in : cfg_q;

  assign joined = (cfg_q.depth == DEPTH_JOIN);
  assign cont   = (cfg_q.mode == MODE_CONT) && !joined;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= cfg_t'{mode: MODE_SEQ, depth: DEPTH_FULL};
      shut_q <= '0;
      act_q  <= 1'b0;
    end else begin
      shut_q <= shutter_i;
      if (cfg_upd_o) begin
        cfg_q <= cfg_d;
        act_q <= 1'b0;
      end else if (cont && shut_q[0] && !shutter_i[0]) begin
        act_q <= ~act_q;
      end
    end
  end

  always_comb begin
    cnt_en = 2'b00;
    shf_o  = 2'b00;
    if (joined) begin
      cnt_en = {2{shutter_i[0] & ~shift_en_i[0]}};
      shf_o  = {2{shift_en_i[0]}};
    end else begin
      unique case (cfg_q.mode)
        MODE_CONT: begin
          cnt_en[act_q]  = shutter_i[0];
          shf_o[~act_q]  = shift_en_i[0];
        end
        MODE_SEMI: begin
          cnt_en = shutter_i & ~shift_en_i;
          shf_o  = shift_en_i;
        end
        default: begin
          cnt_en = {2{shutter_i[0] & ~shift_en_i[0]}};
          shf_o  = {2{shift_en_i[0]}};
        end
      endcase
    end
  end

  // continuous scheme feeds the first threshold to whichever counter is active
  assign ev1   = cont ? rise_i[0] : rise_i[1];
  assign inc_o = cnt_en & {ev1, rise_i[0]};

  always_comb begin
    unique case (cfg_d.depth)
      DEPTH_ONE: mask_nxt_o = MASK_ONE;
      DEPTH_MID: mask_nxt_o = MASK_MID;
      default:   mask_nxt_o = MASK_ALL;
    endcase
  end

  assign join_nxt_o = (cfg_d.depth == DEPTH_JOIN);
  assign cfg_o      = cfg_q;
  assign act_o      = act_q;
endmodule

// File: rtl/pxc_bank.sv
module pxc_bank #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_clr_i,
  input  logic          joined_i,
  input  logic [CW-1:0] mask_i,
  input  logic [1:0]    inc_i,
  input  logic [1:0]    shf_i,
  input  logic          serial_i,
  output logic [CW-1:0] cnt0_o,
  output logic [CW-1:0] cnt1_o,
  output logic          serial_o
);
  localparam int JW = 2 * CW;

  logic [1:0][CW-1:0] cnt_w;
  logic [JW-1:0]      join_q, join_d;
  logic [CW-1:0]      top_bit;
  logic [1:0]         link;

  assign join_q  = {cnt_w[1], cnt_w[0]};
  assign top_bit = mask_i ^ (mask_i >> 1);
  assign link[0] = shf_i[1] ? cnt_w[1][0] : serial_i;
  assign link[1] = serial_i;

  always_comb begin
    join_d = join_q;
    if (shf_i[0])
      join_d = {serial_i, join_q[JW-1:1]};
    else if (inc_i[0] && (join_q != '1))
      join_d = join_q + 1'b1;
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic [CW-1:0] q, sep_d, nxt;

    always_comb begin
      sep_d = q;
      if (shf_i[k])
        sep_d = (q >> 1) | (link[k] ? top_bit : '0);
      else if (inc_i[k] && (q != mask_i))
        sep_d = q + 1'b1;
    end

    assign nxt = joined_i ? join_d[k*CW +: CW] : (sep_d & mask_i);

    always_ff @(posedge clk_i or negedge rst_ni or posedge fast_clr_i) begin
      if (!rst_ni)         q <= '0;
      else if (fast_clr_i) q <= '0;
      else                 q <= nxt;
    end

    assign cnt_w[k] = q;
  end

  assign cnt0_o   = cnt_w[0];
  assign cnt1_o   = cnt_w[1];
  assign serial_o = shf_i[0] ? cnt_w[0][0] : (shf_i[1] ? cnt_w[1][0] : 1'b0);
endmodule

// File: rtl/pxc_pixel.sv
module pxc_pixel
  import pxc_pkg::*;
#(
  parameter int CW    = 12,
  parameter int MID_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_clr_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] depth_i,
  input  logic [1:0] shutter_i,
  input  logic [1:0] evt_i,
  input  logic [1:0] shift_en_i,
  input  logic       serial_i,
  output logic       serial_o
);
  cfg_t          cfg_q;
  logic          cfg_upd, act, join_nxt;
  logic [CW-1:0] mask_nxt, cnt0, cnt1;
  logic [1:0]    rise, inc, shf;

  pxc_evt_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  pxc_ctrl #(.CW(CW), .MID_W(MID_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .depth_i    (depth_i),
    .shutter_i  (shutter_i),
    .shift_en_i (shift_en_i),
    .rise_i     (rise),
    .cfg_o      (cfg_q),
    .cfg_upd_o  (cfg_upd),
    .act_o      (act),
    .join_nxt_o (join_nxt),
    .mask_nxt_o (mask_nxt),
    .inc_o      (inc),
    .shf_o      (shf)
  );

  pxc_bank #(.CW(CW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_clr_i (fast_clr_i),
    .joined_i   (join_nxt),
    .mask_i     (mask_nxt),
    .inc_i      (inc),
    .shf_i      (shf),
    .serial_i   (serial_i),
    .cnt0_o     (cnt0),
    .cnt1_o     (cnt1),
    .serial_o   (serial_o)
  );
endmodule

// File: rtl/pxc_pixel_chk.sv
module pxc_pixel_chk
  import pxc_pkg::*;
#(
  parameter int CW    = 12,
  parameter int MID_W = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fast_clr_i,
  input logic [1:0]    shutter_i,
  input logic [1:0]    shift_en_i,
  input cfg_t          cfg_q,
  input logic          cfg_upd,
  input logic          act,
  input logic [1:0]    shf,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  logic [CW-1:0] lim;
  logic          jn;

  always_comb begin
    unique case (cfg_q.depth)
      DEPTH_ONE: lim = CW'(1);
      DEPTH_MID: lim = CW'((1 << MID_W) - 1);
      default:   lim = '1;
    endcase
  end
  assign jn = (cfg_q.depth == DEPTH_JOIN);

  // R1
  assert_fast_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_clr_i) |-> (cnt0 == '0 && cnt1 == '0));

  // R3
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || fast_clr_i)
    (!jn && cnt0 == lim && !shf[0] && !cfg_upd) |=> (cnt0 == $past(cnt0)));
  assert_no_overflow_join_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || fast_clr_i)
    (jn && {cnt1, cnt0} == '1 && !shf[0] && !cfg_upd) |=> ({cnt1, cnt0} == '1));

  // R2, R5, R9
  assert_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || fast_clr_i)
    (!jn && !shf[1] && !cfg_upd) |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 1'b1));

  // R4
  assert_idle_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || fast_clr_i)
    (cfg_q.mode == MODE_CONT && !jn && !act && !shf[1] && !cfg_upd) |=> $stable(cnt1));

  // R8
  assert_cfg_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shutter_i != 2'b00) || (shift_en_i != 2'b00)) |=> $stable(cfg_q));

  // R10
  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jn |-> (((cnt0 | cnt1) & ~lim) == '0));
endmodule

bind pxc_pixel pxc_pixel_chk #(.CW(CW), .MID_W(MID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fast_clr_i (fast_clr_i),
  .shutter_i  (shutter_i),
  .shift_en_i (shift_en_i),
  .cfg_q      (cfg_q),
  .cfg_upd    (cfg_upd),
  .act        (act),
  .shf        (shf),
  .cnt0       (cnt0),
  .cnt1       (cnt1)
);

// File: tb/pxc_pixel_tb.sv
module pxc_pixel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_clr = 1'b0;
  logic [1:0] mode = 2'd0, depth = 2'd2, shutter = '0, evt = '0, shift_en = '0;
  logic       serial_in = 1'b0;
  logic       serial_out;

  int   n_chk = 0, n_fail = 0;
  logic exp_q[$];
  string tag_q[$];
  logic mon_en = 1'b0;
  logic eb;
  string tg;

  always #2 clk = ~clk;

  pxc_pixel u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fast_clr_i (fast_clr),
    .mode_i     (mode),
    .depth_i    (depth),
    .shutter_i  (shutter),
    .evt_i      (evt),
    .shift_en_i (shift_en),
    .serial_i   (serial_in),
    .serial_o   (serial_out)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // monitor: pops one expected bit per shifting cycle
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard underrun actual=%0b expected=none", serial_out);
      end else begin
        eb = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (serial_out !== eb) begin
          n_fail++;
          $display("FAIL %s actual=%0b expected=%0b", tg, serial_out, eb);
        end
      end
    end
  end

  task automatic readout(input int n, input logic [1:0] en, input logic [23:0] expv,
                         input logic [23:0] sin, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(expv[i]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      shift_en  = en;
      serial_in = sin[i];
      mon_en    = 1'b1;
      @(negedge clk);
    end
    shift_en  = '0;
    serial_in = 1'b0;
    mon_en    = 1'b0;
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt[k] = 1'b1;
      @(negedge clk); evt[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] d);
    @(negedge clk);
    mode  = m;
    depth = d;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 serial_o in reset", serial_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 serial_o idle after reset", serial_out, 0);

    // R2, R9: sequential, 12-bit, one held-high event
    shutter = 2'b01;
    pulse(0, 5);
    pulse(1, 3);
    @(negedge clk); evt[0] = 1'b1;
    repeat (6) @(negedge clk); evt[0] = 1'b0;
    repeat (3) @(negedge clk);
    shutter = 2'b00;
    readout(24, 2'b01, {12'd3, 12'd6}, 24'h0, "R2 R9 seq 12b");
    readout(24, 2'b01, 24'h0, 24'h0, "R7 cleared by zeros");

    // R3, R10, R7: 4-bit saturation and serial load
    set_cfg(2'd0, 2'd1);
    shutter = 2'b01;
    pulse(0, 20);
    pulse(1, 2);
    shutter = 2'b00;
    readout(8, 2'b01, 24'h2F, 24'hA5, "R3 R10 seq 4b saturate");
    readout(8, 2'b01, 24'hA5, 24'h0, "R7 serial load");

    // R3, R10: 1-bit depth
    set_cfg(2'd0, 2'd0);
    shutter = 2'b01;
    pulse(0, 3);
    shutter = 2'b00;
    readout(2, 2'b01, 24'h1, 24'h0, "R3 R10 seq 1b");

    // R8: mode change during exposure is ignored
    set_cfg(2'd0, 2'd1);
    shutter = 2'b01;
    @(negedge clk); mode = 2'd1;
    pulse(1, 2);
    pulse(0, 1);
    @(negedge clk); mode = 2'd0;
    shutter = 2'b00;
    readout(8, 2'b01, 24'h21, 24'h0, "R8 cfg held while open");

    // R4: continuous, counting overlaps readout
    set_cfg(2'd1, 2'd1);
    shutter = 2'b01;
    pulse(0, 5);
    pulse(1, 4);
    @(negedge clk); shutter = 2'b00;
    @(negedge clk); shutter = 2'b01;
    fork
      pulse(0, 3);
      readout(4, 2'b01, 24'h5, 24'h0, "R4 frame A from counter 0");
    join
    @(negedge clk); shutter = 2'b00;
    readout(4, 2'b01, 24'h3, 24'h0, "R4 frame B from counter 1");

    // R5: semi-sequential
    set_cfg(2'd2, 2'd2);
    shutter = 2'b01;
    pulse(0, 4);
    shutter = 2'b11;
    pulse(1, 2);
    pulse(0, 1);
    shutter = 2'b10;
    fork
      pulse(1, 1);
      readout(12, 2'b01, 24'h5, 24'h0, "R5 counter 0 alone");
    join
    shutter = 2'b00;
    readout(12, 2'b10, 24'h3, 24'h0, "R5 counter 1 alone");

    // R6, R3, R7: joined 24-bit
    set_cfg(2'd0, 2'd3);
    shutter = 2'b01;
    pulse(0, 7);
    pulse(1, 3);
    shutter = 2'b00;
    readout(24, 2'b01, 24'h7, 24'hFFFFFD, "R6 joined count");
    shutter = 2'b01;
    pulse(0, 4);
    shutter = 2'b00;
    readout(24, 2'b01, 24'hFFFFFF, 24'h0, "R3 R6 joined saturate");

    // R1: fast clear
    set_cfg(2'd0, 2'd2);
    shutter = 2'b01;
    pulse(0, 2);
    pulse(1, 1);
    shutter = 2'b00;
    @(negedge clk); fast_clr = 1'b1;
    @(negedge clk); fast_clr = 1'b0;
    chk("R1 serial_o idle after clear", serial_out, 0);
    readout(24, 2'b01, 24'h0, 24'h0, "R1 fast clear");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule